// File: doc/BRIEF.md
# Receive Ring Page Manager

This block places received frames into a circular region of local packet memory. The region is split into 256-byte pages and runs from a start page up to, but not including, a stop page. For each frame, the payload bytes go to memory from offset 4 of the current page onward. They move on page by page and wrap from the stop page back to the start page. Once the whole frame has arrived, the block writes a 4-byte header into the first four bytes of the frame's first page. It then moves its current-page pointer to the page after the frame and raises a one-cycle receive interrupt.

The host owns a boundary register that names the page it has not yet released. The block never moves into that page. If a frame would need it, the frame is abandoned and an overwrite interrupt is raised. Runt frames and oversize frames are dropped without touching the pointer. The host seeds the current pointer through a load strobe. The incoming byte stream must leave at least five idle cycles after each end strobe, because the header is written in that gap.

Top module: `rxring_pager`

## Requirements
- R1: The first payload byte of a frame is written to byte address (current page × 256) + 4, and each later byte goes to the next offset.
- R2: After offset 255, writing continues at offset 0 of the following page, and the page after stop−1 is the start page.
- R3: After the frame end, the first page of the frame receives a header: offset 0 the status byte, offset 1 the next-page pointer, offset 2 the low byte of the length, offset 3 the high byte of the length.
- R4: The length field equals the number of bytes received for the frame, including its 4-byte CRC.
- R5: The next-page pointer is the wrapped page after the page that holds the last payload byte. After commit, cur_page takes that value.
- R6: cur_page changes and irq_rx pulses for one cycle in the cycle after the header byte at offset 3 is written, and not otherwise except on a load.
- R7: If moving to a new page, or the final next-page pointer, would equal ring_bound, no further byte is written, no header is written, cur_page is unchanged, irq_ovw pulses once after the end strobe and rx_status becomes 0x08 (overflow, bit 3).
- R8: A frame of fewer than MIN_LEN (64) bytes is discarded: no header, no irq, cur_page unchanged. A frame of exactly 64 bytes is stored.
- R9: A frame longer than MAX_LEN (1518) bytes is discarded with at most 1518 payload writes, no header and cur_page unchanged. A frame of exactly 1518 bytes is stored.
- R10: The header status byte and rx_status after a commit both equal the rx_stat_in value presented with the end strobe. Bit 0 is the good-frame flag and is passed through unchanged.
- R11: A cur_load pulse sets cur_page to cur_value on the next clock.
- R12: After reset, cur_page and rx_status are 0, and irq_rx, irq_ovw and mem_we are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | A frame byte is present on rx_byte |
| rx_byte | input | 8 | Frame byte |
| rx_end | input | 1 | End-of-frame strobe, with no byte attached |
| rx_stat_in | input | 8 | Receive status, valid with rx_end |
| ring_start | input | PAGE_W | First page of the ring |
| ring_stop | input | PAGE_W | Page just past the ring |
| ring_bound | input | PAGE_W | Host boundary page that must not be entered |
| cur_load | input | 1 | Load cur_value into the current-page pointer |
| cur_value | input | PAGE_W | Value for cur_load |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | PAGE_W+8 | Byte address: page × 256 + offset |
| mem_wdata | output | 8 | Memory write data |
| cur_page | output | PAGE_W | Current-page pointer |
| irq_rx | output | 1 | One-cycle pulse when a frame is committed |
| irq_ovw | output | 1 | One-cycle pulse when a frame is lost to the boundary |
| rx_status | output | 8 | Status of the last committed or lost frame |

## Verification
The bench drives frames that end exactly on a page edge, so a design that bumps the page one time too many leaves a hole in the next-page pointer. It also drives frames that straddle the stop page, where a wrong wrap writes past the ring or into the wrong page. It sets the boundary so that overflow hits both partway through a frame and only on the final pointer. A design that checks only one of these cases overwrites host data or commits a frame that should be lost. Lengths of 63, 64, 1518 and 1519 bytes catch an off-by-one in either length limit. The bench times the interrupt against the last header write to catch a pointer that moves before the header is in memory.

// File: rtl/rxring_pkg.sv
package rxring_pkg;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_DATA,
      ST_DROP,
      ST_HDR
   } rx_state_e;

   localparam int HDR_BYTES     = 4;
   localparam int PAGE_BYTES    = 256;
   localparam logic [7:0] STAT_OVERRUN = 8'h08;

endpackage

// File: rtl/rxring_wrap.sv
// Page successor within the ring: stop is exclusive, wraps to start.
module rxring_wrap #(
   parameter int PAGE_W = 8
) (
   input  logic [PAGE_W-1:0] page,
   input  logic [PAGE_W-1:0] start_pg,
   input  logic [PAGE_W-1:0] stop_pg,
   output logic [PAGE_W-1:0] next_pg
);
   logic [PAGE_W-1:0] plus_one;

   assign plus_one = page + 1'b1;
   assign next_pg  = (plus_one == stop_pg) ? start_pg : plus_one;

endmodule

// File: rtl/rxring_lencnt.sv
// Frame byte counter with runt and oversize limits.
module rxring_lencnt #(
   parameter int LEN_W   = 16,
   parameter int MIN_LEN = 64,
   parameter int MAX_LEN = 1518
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_one,
   input  logic             bump,
   output logic [LEN_W-1:0] count,
   output logic             at_max,
   output logic             too_short
);
   localparam logic [LEN_W-1:0] MIN_V = LEN_W'(MIN_LEN);
   localparam logic [LEN_W-1:0] MAX_V = LEN_W'(MAX_LEN);

   generate
      if (MAX_LEN >= (1 << LEN_W)) begin : g_bad_width
         $error("rxring_lencnt: MAX_LEN does not fit in LEN_W");
      end
      if (MIN_LEN < 1 || MIN_LEN > MAX_LEN) begin : g_bad_limits
         $error("rxring_lencnt: MIN_LEN must lie in 1..MAX_LEN");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        count <= '0;
      else if (load_one) count <= LEN_W'(1);
      else if (bump)     count <= count + 1'b1;
   end

   assign at_max    = (count == MAX_V);
   assign too_short = (count < MIN_V);

endmodule

// File: rtl/rxring_hdr.sv
// Header byte select: status, next page, length low, length high.
module rxring_hdr #(
   parameter int PAGE_W = 8,
   parameter int LEN_W  = 16
) (
   input  logic [1:0]        idx,
   input  logic [7:0]        status,
   input  logic [PAGE_W-1:0] next_pg,
   input  logic [LEN_W-1:0]  len,
   output logic [7:0]        hbyte
);
   logic [15:0] len16;
   logic [7:0]  lane [4];

   generate
      if (PAGE_W > 8) begin : g_bad_page
         $error("rxring_hdr: next-page field is one byte");
      end
      if (LEN_W > 16) begin : g_bad_len
         $error("rxring_hdr: length field is two bytes");
      end
   endgenerate

   assign len16   = 16'(len);
   assign lane[0] = status;
   assign lane[1] = 8'(next_pg);

   for (genvar k = 0; k < 2; k++) begin : g_len_lane
      assign lane[2+k] = len16[8*k +: 8];
   end

   assign hbyte = lane[idx];

endmodule

// File: rtl/rxring_pager.sv
module rxring_pager
   import rxring_pkg::*;
#(
   parameter int PAGE_W  = 8,
   parameter int LEN_W   = 16,
   parameter int MIN_LEN = 64,
   parameter int MAX_LEN = 1518
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic [7:0]        rx_byte,
   input  logic              rx_end,
   input  logic [7:0]        rx_stat_in,
   input  logic [PAGE_W-1:0] ring_start,
   input  logic [PAGE_W-1:0] ring_stop,
   input  logic [PAGE_W-1:0] ring_bound,
   input  logic              cur_load,
   input  logic [PAGE_W-1:0] cur_value,
   output logic              mem_we,
   output logic [PAGE_W+7:0] mem_addr,
   output logic [7:0]        mem_wdata,
   output logic [PAGE_W-1:0] cur_page,
   output logic              irq_rx,
   output logic              irq_ovw,
   output logic [7:0]        rx_status
);
   localparam logic [7:0] FIRST_OFF = 8'(HDR_BYTES);
   localparam logic [1:0] LAST_HDR  = 2'(HDR_BYTES - 1);

   rx_state_e         state_q;
   logic [PAGE_W-1:0] first_q, wpage_q, next_q;
   logic [7:0]        woff_q, stat_q;
   logic [1:0]        hidx_q;
   logic              ovf_q;

   logic [PAGE_W-1:0] wrap_nxt, end_next;
   logic [LEN_W-1:0]  cnt;
   logic              cnt_at_max, cnt_short;
   logic              take_first, data_wr, hdr_wr;
   logic [7:0]        hdr_byte;

   // ---------------- submodules ----------------
   rxring_wrap #(.PAGE_W(PAGE_W)) u_wrap (
      .page     (wpage_q),
      .start_pg (ring_start),
      .stop_pg  (ring_stop),
      .next_pg  (wrap_nxt)
   );

   rxring_lencnt #(
      .LEN_W(LEN_W), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)
   ) u_len (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_one  (take_first),
      .bump      (data_wr),
      .count     (cnt),
      .at_max    (cnt_at_max),
      .too_short (cnt_short)
   );

   rxring_hdr #(.PAGE_W(PAGE_W), .LEN_W(LEN_W)) u_hdr (
      .idx     (hidx_q),
      .status  (stat_q),
      .next_pg (next_q),
      .len     (cnt),
      .hbyte   (hdr_byte)
   );

   // ---------------- write port ----------------
   assign take_first = (state_q == ST_IDLE) && rx_valid && !cur_load;
   assign data_wr    = (state_q == ST_DATA) && rx_valid && !cnt_at_max && !cur_load;
   assign hdr_wr     = (state_q == ST_HDR);
   assign end_next   = (woff_q == 8'd0) ? wpage_q : wrap_nxt;

   assign mem_we    = take_first || data_wr || hdr_wr;
   assign mem_wdata = hdr_wr ? hdr_byte : rx_byte;

   always_comb begin
      if (hdr_wr)
         mem_addr = {first_q, 6'd0, hidx_q};
      else if (state_q == ST_IDLE)
         mem_addr = {cur_page, FIRST_OFF};
      else
         mem_addr = {wpage_q, woff_q};
   end

   // ---------------- sequencing ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         first_q   <= '0;
         wpage_q   <= '0;
         next_q    <= '0;
         woff_q    <= '0;
         stat_q    <= '0;
         hidx_q    <= '0;
         ovf_q     <= 1'b0;
         cur_page  <= '0;
         irq_rx    <= 1'b0;
         irq_ovw   <= 1'b0;
         rx_status <= '0;
      end else begin
         irq_rx  <= 1'b0;
         irq_ovw <= 1'b0;
         if (cur_load) begin
            cur_page <= cur_value;
            state_q  <= ST_IDLE;
            ovf_q    <= 1'b0;
         end else begin
            unique case (state_q)
               ST_IDLE: begin
                  if (rx_valid) begin
                     first_q <= cur_page;
                     wpage_q <= cur_page;
                     woff_q  <= FIRST_OFF + 8'd1;
                     ovf_q   <= 1'b0;
                     state_q <= ST_DATA;
                  end
               end
               ST_DATA: begin
                  if (rx_valid) begin
                     if (cnt_at_max) begin
                        state_q <= ST_DROP;
                     end else begin
                        woff_q <= woff_q + 8'd1;
                        if (woff_q == 8'hFF) begin
                           if (wrap_nxt == ring_bound) begin
                              ovf_q   <= 1'b1;
                              state_q <= ST_DROP;
                           end else begin
                              wpage_q <= wrap_nxt;
                           end
                        end
                     end
                  end else if (rx_end) begin
                     if (cnt_short) begin
                        state_q <= ST_IDLE;
                     end else if (end_next == ring_bound) begin
                        irq_ovw   <= 1'b1;
                        rx_status <= STAT_OVERRUN;
                        state_q   <= ST_IDLE;
                     end else begin
                        stat_q  <= rx_stat_in;
                        next_q  <= end_next;
                        hidx_q  <= '0;
                        state_q <= ST_HDR;
                     end
                  end
               end
               ST_DROP: begin
                  if (rx_end) begin
                     if (ovf_q) begin
                        irq_ovw   <= 1'b1;
                        rx_status <= STAT_OVERRUN;
                     end
                     ovf_q   <= 1'b0;
                     state_q <= ST_IDLE;
                  end
               end
               ST_HDR: begin
                  hidx_q <= hidx_q + 2'd1;
                  if (hidx_q == LAST_HDR) begin
                     cur_page  <= next_q;
                     irq_rx    <= 1'b1;
                     rx_status <= stat_q;
                     state_q   <= ST_IDLE;
                  end
               end
               default: state_q <= ST_IDLE;
            endcase
         end
      end
   end

   // ---------------- assertions ----------------
   // R2: every write lands inside the ring
   a_r2_write_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (mem_addr[PAGE_W+7:8] >= ring_start && mem_addr[PAGE_W+7:8] < ring_stop));

   // R7: payload never enters the boundary page
   a_r7_bound_untouched: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && !hdr_wr) |-> (mem_addr[PAGE_W+7:8] != ring_bound));

   // R6: commit follows the last header byte
   a_r6_commit_after_hdr: assert property (@(posedge clk) disable iff (!rst_n)
      irq_rx |-> $past(state_q == ST_HDR && hidx_q == LAST_HDR));

   // R6: pointer moves only on commit or load
   a_r6_cur_moves_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_page != $past(cur_page)) |-> (irq_rx || $past(cur_load)));

   // R7: a frame is either committed or lost, never both
   a_r7_irq_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(irq_rx && irq_ovw));

   // R5: committed pointer stays in the ring
   a_r5_next_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
      irq_rx |-> (cur_page >= ring_start && cur_page < ring_stop));

endmodule

// File: tb/rxring_pager_tb_top.sv
`timescale 1ns/1ps
module rxring_pager_tb_top;
   localparam int PW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rx_valid = 1'b0, rx_end = 1'b0, cur_load = 1'b0;
   logic [7:0]    rx_byte = '0, rx_stat_in = '0;
   logic [PW-1:0] ring_start = '0, ring_stop = '0, ring_bound = '0, cur_value = '0;
   logic          mem_we, irq_rx, irq_ovw;
   logic [PW+7:0] mem_addr;
   logic [7:0]    mem_wdata, rx_status;
   logic [PW-1:0] cur_page;

   always #2.5 clk = ~clk;

   rxring_pager #(.PAGE_W(PW)) dut_i (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
      .rx_end(rx_end), .rx_stat_in(rx_stat_in), .ring_start(ring_start),
      .ring_stop(ring_stop), .ring_bound(ring_bound), .cur_load(cur_load),
      .cur_value(cur_value), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .cur_page(cur_page), .irq_rx(irq_rx),
      .irq_ovw(irq_ovw), .rx_status(rx_status)
   );

   int nchk = 0, nerr = 0, cyc = 0;
   int n_rx, n_ovw, nwr, hdr_hits, bad_hits, t_hdr, t_irq;
   int watch_page = -1, watch_bad = -1;
   bit finished = 0;
   logic [7:0] mem [int];

   // Monitor away from the clock edge
   always @(negedge clk) begin
      cyc++;
      if (mem_we) begin
         mem[int'(mem_addr)] = mem_wdata;
         nwr++;
         if (int'(mem_addr[15:8]) == watch_page && mem_addr[7:0] < 8'd4) hdr_hits++;
         if (int'(mem_addr[15:8]) == watch_bad) bad_hits++;
         if (int'(mem_addr[15:8]) == watch_page && mem_addr[7:0] == 8'd3) t_hdr = cyc;
      end
      if (irq_rx) begin n_rx++; t_irq = cyc; end
      if (irq_ovw) n_ovw++;
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] pat(input int i, input int s);
      return 8'(i * 7 + s);
   endfunction

   function automatic int addr_of(input int first, input int pos);
      int pg = first;
      for (int k = 0; k < pos / 256; k++)
         pg = (pg + 1 == int'(ring_stop)) ? int'(ring_start) : pg + 1;
      return pg * 256 + (pos % 256);
   endfunction

   task automatic setup(input int cur, input int st, input int sp, input int bd);
      @(posedge clk); #1;
      ring_start = PW'(st); ring_stop = PW'(sp); ring_bound = PW'(bd);
      cur_value = PW'(cur); cur_load = 1'b1;
      @(posedge clk); #1;
      cur_load = 1'b0;
      @(negedge clk);
      chk(cur_page == PW'(cur), "R11 cur_load", cur_page, cur);
   endtask

   task automatic send(input int n, input logic [7:0] st, input int seed);
      n_rx = 0; n_ovw = 0; nwr = 0; hdr_hits = 0; bad_hits = 0; t_hdr = -10; t_irq = -20;
      watch_page = int'(cur_page);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1;
         rx_valid = 1'b1; rx_byte = pat(i, seed);
      end
      @(posedge clk); #1;
      rx_valid = 1'b0; rx_end = 1'b1; rx_stat_in = st;
      @(posedge clk); #1;
      rx_end = 1'b0;
      repeat (8) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check_frame(input int first, input int n, input logic [7:0] st,
                              input int seed, input int nxt);
      int bad = 0;
      for (int i = 0; i < n; i++)
         if (!mem.exists(addr_of(first, i + 4)) || mem[addr_of(first, i + 4)] !== pat(i, seed)) bad++;
      chk(bad == 0, "R1 R2 payload placement", bad, 0);
      chk(mem[first*256] == st, "R3 R10 header status", mem[first*256], st);
      chk(mem[first*256+1] == 8'(nxt), "R3 R5 header next page", mem[first*256+1], nxt);
      chk({mem[first*256+3], mem[first*256+2]} == 16'(n), "R4 header length",
          {mem[first*256+3], mem[first*256+2]}, n);
      chk(cur_page == PW'(nxt), "R5 cur after commit", cur_page, nxt);
      chk(n_rx == 1 && t_irq == t_hdr + 1, "R6 commit timing", t_irq - t_hdr, 1);
      chk(rx_status == st, "R10 rx_status", rx_status, st);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(cur_page == 0 && rx_status == 0, "R12 reset regs", {cur_page, rx_status}, 0);
      chk(!irq_rx && !irq_ovw && !mem_we, "R12 reset strobes", {irq_rx, irq_ovw, mem_we}, 0);
   endtask

   task automatic t_basic();
      setup(8'h46, 8'h46, 8'h80, 8'h7F);
      send(100, 8'h01, 3);
      check_frame(8'h46, 100, 8'h01, 3, 8'h47);
   endtask

   task automatic t_span();
      send(600, 8'h01, 5);
      check_frame(8'h47, 600, 8'h01, 5, 8'h4A);
   endtask

   task automatic t_exact();
      send(252, 8'h01, 11);
      check_frame(8'h4A, 252, 8'h01, 11, 8'h4B);
   endtask

   task automatic t_wrap();
      setup(8'h7F, 8'h46, 8'h80, 8'h50);
      send(300, 8'h21, 9);
      check_frame(8'h7F, 300, 8'h21, 9, 8'h47);
      chk(mem[16'h4600] == pat(252, 9), "R2 wrap to start page", mem[16'h4600], pat(252, 9));
   endtask

   task automatic t_ovf_mid();
      setup(8'h48, 8'h46, 8'h80, 8'h4A);
      watch_bad = 8'h4A;
      send(600, 8'h01, 13);
      chk(bad_hits == 0 && nwr == 508, "R7 writes stop before boundary", nwr, 508);
      chk(hdr_hits == 0 && n_rx == 0, "R7 no header on overflow", hdr_hits, 0);
      chk(n_ovw == 1 && cur_page == 8'h48, "R7 ovw and cur kept", {n_ovw, cur_page}, {1, 8'h48});
      chk(rx_status == 8'h08, "R7 overflow status", rx_status, 8'h08);
      watch_bad = -1;
   endtask

   task automatic t_ovf_end();
      setup(8'h48, 8'h46, 8'h80, 8'h49);
      send(100, 8'h01, 17);
      chk(n_ovw == 1 && n_rx == 0 && hdr_hits == 0, "R7 final pointer hits bound", n_ovw, 1);
      chk(cur_page == 8'h48, "R7 cur kept at end overflow", cur_page, 8'h48);
   endtask

   task automatic t_short();
      setup(8'h50, 8'h46, 8'h80, 8'h4F);
      send(63, 8'h01, 19);
      chk(n_rx == 0 && n_ovw == 0 && hdr_hits == 0, "R8 runt dropped", n_rx, 0);
      chk(cur_page == 8'h50, "R8 cur kept on runt", cur_page, 8'h50);
      send(64, 8'h01, 23);
      check_frame(8'h50, 64, 8'h01, 23, 8'h51);
   endtask

   task automatic t_long();
      setup(8'h52, 8'h46, 8'h80, 8'h4F);
      send(1519, 8'h01, 29);
      chk(n_rx == 0 && hdr_hits == 0 && n_ovw == 0, "R9 oversize dropped", n_rx, 0);
      chk(nwr == 1518, "R9 writes capped", nwr, 1518);
      chk(cur_page == 8'h52, "R9 cur kept on oversize", cur_page, 8'h52);
      send(1518, 8'h01, 31);
      check_frame(8'h52, 1518, 8'h01, 31, 8'h58);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("CHECKS %0d ERRORS %0d", nchk, nerr);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      t_reset();
      #1 rst_n = 1'b1;
      t_basic();
      t_span();
      t_exact();
      t_wrap();
      t_ovf_mid();
      t_ovf_end();
      t_short();
      t_long();
      finish_run();
   end

   initial begin
      #(200000 * 5);
      nchk++; nerr++;
      $display("FAIL watchdog expired");
      finish_run();
   end

endmodule